// File: doc/BRIEF.md
# LIN master header transmitter

This block turns a plain 8N1 serial transmitter into the sending side of a LIN bus master. Once a start pulse is taken while master operation is enabled, it holds the line dominant (low) for a Sync Break of 13 to 16 bit times, set by a 2-bit length code. It then drives the line recessive for one bit time as the break delimiter. After that it sends bytes from a byte stream as standard characters until it has sent the byte that carries the last-byte marker.

The stream must present the frame bytes in LIN order. The sync value 0x55 comes first, then the identifier, then the data bytes, and the checksum is last. The block forwards the bytes unchanged and does not compute a checksum or an identifier parity. Bit timing comes entirely from a one-cycle baud-tick strobe, so one bit time is the interval between two ticks. A busy flag covers the whole frame. A one-cycle done pulse marks its end.

Top module: `lin_hdr_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is 1, `busy` is 0 and `done` is 0.
- R2: A `start` pulse is taken only while idle with `master_en` = 1. A pulse with `master_en` = 0 has no effect: `busy` stays 0 and `txd` stays 1.
- R3: After a frame is taken, `txd` goes low at the first `baud_tick` and stays low for 13 + `brk_len` tick periods. The codes are 0 → 13, 1 → 14, 2 → 15 and 3 → 16.
- R4: When the break ends, `txd` is high for exactly one tick period before the first start bit, provided a byte is offered at that tick.
- R5: Each byte is sent as a start bit (0), eight data bits LSB first, and a stop bit (1). Each of these bits lasts one tick period.
- R6: Bytes are taken through a handshake, in stream order, on cycles where `tx_ready` and `tx_valid` are both 1. `tx_ready` is 1 only in a `baud_tick` cycle that ends the delimiter, ends the stop bit of a byte not marked last, or falls in a gap that is waiting for a byte. A byte offered at the end of a stop bit starts its start bit at once, with no idle bit between characters.
- R7: `done` is 1 for exactly one cycle, in the cycle after the tick that ends the stop bit of the byte taken with `tx_last` = 1. `busy` falls in that same cycle.
- R8: A `start` pulse that arrives while `busy` is 1 is ignored. The frame in progress goes on unchanged.
- R9: If no byte is valid at a byte boundary, `txd` stays high. The next start bit begins at the first tick where a byte is valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle strobe that marks each bit-time boundary |
| master_en | input | 1 | Enables master operation; sampled when a start is taken |
| brk_len | input | 2 | Break length code: 13 + code bit times |
| start | input | 1 | Request to send one frame |
| tx_data | input | 8 | Byte offered from the stream |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_last | input | 1 | Offered byte is the final byte of the frame |
| tx_ready | output | 1 | Byte taken this cycle when `tx_valid` is 1 |
| txd | output | 1 | Serial line (1 = recessive) |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The assertions assume that `baud_tick` is a single-cycle strobe with at least one idle cycle between ticks. They also assume that `brk_len`, `tx_data` and `tx_last` are stable whenever they are sampled. The stimulus keeps to these assumptions: it fires a tick every fourth clock, and it changes the stream inputs only away from the clock edge, straight after each handshake. It varies all four break codes, stalls the stream across a byte boundary, and sends start pulses both with master operation disabled and in the middle of a frame.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_BRK,
    ST_GAP,
    ST_CHAR
  } lin_st_t;

  // Break length in bit times for a given length code.
  function automatic int unsigned brk_bits(input int unsigned base, input int unsigned code);
    return base + code;
  endfunction

endpackage

// File: rtl/lin_brk_timer.sv
module lin_brk_timer #(
  parameter int LEN_W   = 2,
  parameter int BRK_MIN = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             arm,
  input  logic [LEN_W-1:0] len,
  output logic             low,
  output logic             brk_end
);
  import lin_hdr_pkg::*;

  localparam int MAX_BITS = BRK_MIN + (1 << LEN_W) - 1;
  localparam int CW       = $clog2(MAX_BITS + 1);

  logic [CW-1:0]    cnt;
  logic [CW-1:0]    lim;
  logic [LEN_W-1:0] len_q;
  logic             act;

  assign lim     = CW'(brk_bits(BRK_MIN, int'(len_q)));
  assign low     = act;
  assign brk_end = act && tick && (cnt == lim - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act   <= 1'b0;
      cnt   <= '0;
      len_q <= '0;
    end else if (arm) begin
      act   <= 1'b1;
      cnt   <= '0;
      len_q <= len;
    end else if (act && tick) begin
      if (brk_end) act <= 1'b0;
      else         cnt <= cnt + CW'(1);
    end
  end

  // Independent tick tally for the length check.
  logic [CW-1:0] chk_ticks;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           chk_ticks <= '0;
    else if (arm)         chk_ticks <= '0;
    else if (act && tick) chk_ticks <= chk_ticks + CW'(1);
  end

  p_brk_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    brk_end |-> (int'(chk_ticks) + 1 == int'(brk_bits(BRK_MIN, int'(len_q)))));

  p_brk_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_end && !arm) |=> !low);

endmodule

// File: rtl/lin_char_shift.sv
module lin_char_shift #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 load,
  input  logic [DATA_BITS-1:0] data,
  output logic                 bit_out,
  output logic                 active,
  output logic                 char_end
);
  localparam int FRAME_BITS = DATA_BITS + 2;
  localparam int CW         = $clog2(FRAME_BITS);

  // Stop bit, data bits, start bit: the LSB goes out first.
  function automatic logic [FRAME_BITS-1:0] frame_word(input logic [DATA_BITS-1:0] d);
    return {1'b1, d, 1'b0};
  endfunction

  logic [FRAME_BITS-1:0] shreg;
  logic [CW-1:0]         cnt;
  logic                  act;

  assign active   = act;
  assign bit_out  = act ? shreg[0] : 1'b1;
  assign char_end = act && tick && (cnt == CW'(FRAME_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '1;
      cnt   <= '0;
      act   <= 1'b0;
    end else if (load) begin
      shreg <= frame_word(data);
      cnt   <= '0;
      act   <= 1'b1;
    end else if (act && tick) begin
      if (char_end) begin
        act <= 1'b0;
      end else begin
        shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
        cnt   <= cnt + CW'(1);
      end
    end
  end

  p_load_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> tick);

  p_char_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (char_end && !load) |=> (!active && bit_out));

endmodule

// File: rtl/lin_hdr_tx.sv
module lin_hdr_tx
  import lin_hdr_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int LEN_W     = 2,
  parameter int BRK_MIN   = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 baud_tick,
  input  logic                 master_en,
  input  logic [LEN_W-1:0]     brk_len,
  input  logic                 start,
  input  logic [DATA_BITS-1:0] tx_data,
  input  logic                 tx_valid,
  input  logic                 tx_last,
  output logic                 tx_ready,
  output logic                 txd,
  output logic                 busy,
  output logic                 done
);

  lin_st_t          st, st_nx;
  logic             cur_last;
  logic             done_q;
  logic [LEN_W-1:0] len_q;

  // Named internal events
  logic accept, brk_arm, brk_low, brk_end;
  logic byte_slot, sh_load, sh_bit, sh_act, sh_end;
  logic frame_end;

  assign accept    = (st == ST_IDLE) && start && master_en;
  assign brk_arm   = (st == ST_ARM) && baud_tick;
  assign byte_slot = ((st == ST_GAP) && baud_tick) ||
                     ((st == ST_CHAR) && sh_end && !cur_last);
  assign sh_load   = byte_slot && tx_valid;
  assign frame_end = (st == ST_CHAR) && sh_end && cur_last;

  lin_brk_timer #(
    .LEN_W  (LEN_W),
    .BRK_MIN(BRK_MIN)
  ) u_brk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (baud_tick),
    .arm    (brk_arm),
    .len    (len_q),
    .low    (brk_low),
    .brk_end(brk_end)
  );

  lin_char_shift #(
    .DATA_BITS(DATA_BITS)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (baud_tick),
    .load    (sh_load),
    .data    (tx_data),
    .bit_out (sh_bit),
    .active  (sh_act),
    .char_end(sh_end)
  );

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: if (accept)    st_nx = ST_ARM;
      ST_ARM:  if (baud_tick) st_nx = ST_BRK;
      ST_BRK:  if (brk_end)   st_nx = ST_GAP;
      ST_GAP:  if (sh_load)   st_nx = ST_CHAR;
      ST_CHAR: begin
        if (frame_end)    st_nx = ST_IDLE;
        else if (sh_load) st_nx = ST_CHAR;
        else if (sh_end)  st_nx = ST_GAP;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cur_last <= 1'b0;
      len_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      st     <= st_nx;
      done_q <= frame_end;
      if (accept)  len_q    <= brk_len;
      if (sh_load) cur_last <= tx_last;
    end
  end

  always_comb begin
    unique case (st)
      ST_BRK:  txd = !brk_low;
      ST_CHAR: txd = sh_bit;
      default: txd = 1'b1;
    endcase
  end

  assign tx_ready = byte_slot;
  assign busy     = (st != ST_IDLE);
  assign done     = done_q;

  p_idle_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (txd && !tx_ready));

  p_enable_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !master_en) |=> !busy);

  p_delimiter_r4: assert property (@(posedge clk) disable iff (!rst_n)
    brk_end |=> (txd && (st == ST_GAP)));

  p_gap_idle_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_GAP) |-> !sh_act);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (st != ST_ARM) && start) |=> (st != ST_ARM));

endmodule

// File: tb/lin_hdr_tx_bench.sv
module lin_hdr_tx_bench;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0, master_en = 1'b0, start = 1'b0;
  logic [1:0] brk_len = 2'd0;
  logic [7:0] tx_data = 8'd0;
  logic       tx_valid = 1'b0, tx_last = 1'b0;
  logic       tx_ready, txd, busy, done;

  lin_hdr_tx u_lin_hdr_tx (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .master_en(master_en),
    .brk_len(brk_len), .start(start), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_last(tx_last), .tx_ready(tx_ready), .txd(txd), .busy(busy), .done(done)
  );

  int total = 0, bad = 0;
  int cyc = 0, tick_div = 0, done_seen = 0;

  // Requests from the main sequence, applied at the next falling edge
  bit         req_start = 0, req_en = 0, stall = 0;
  logic [1:0] req_len = 2'd0;
  int         frm[$];
  int         idx = 0;

  // Reference model. Codes: 0 break, 3 delimiter, 2 start bit,
  // 10/11 data bit value 0/1, 12 stop bit.
  int    q[$];
  bit    m_busy = 0, m_txd = 1, m_done = 0, m_ready;
  string m_tag = "R1";

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic string tag_of(input int code);
    if (code == 0) return "R3";
    if (code == 3) return "R4";
    return "R5";
  endfunction

  always begin
    @(negedge clk);
    if (rst_n) begin
      cyc++;
      if (cyc > 150000) begin
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        finish_run();
      end
      chk({txd, busy, done} === {m_txd, m_busy, m_done}, m_tag, "txd/busy/done",
          int'({txd, busy, done}), int'({m_txd, m_busy, m_done}));
      if (done === 1'b1) done_seen++;
      baud_tick = (tick_div == 3);
      tick_div  = (tick_div + 1) % 4;
      start     = req_start; req_start = 0;
      master_en = req_en;
      brk_len   = req_len;
      tx_valid  = (idx < frm.size()) && !stall;
      tx_data   = (idx < frm.size()) ? 8'(frm[idx]) : 8'd0;
      tx_last   = (idx == frm.size() - 1);
      #5;
      m_ready = m_busy && baud_tick && (q.size() > 0) && (q[0] == 2);
      chk(tx_ready === m_ready, "R6", "tx_ready", int'(tx_ready), int'(m_ready));
      m_done = 0;
      if (!m_busy) begin
        m_tag = start ? "R2" : "R1";
        if (start && master_en) begin
          m_busy = 1;
          m_tag  = "R3";
          q.delete();
          for (int i = 0; i < 13 + int'(brk_len); i++) q.push_back(0);
          q.push_back(3);
          foreach (frm[k]) begin
            q.push_back(2);
            for (int b = 0; b < 8; b++) q.push_back(10 + ((frm[k] >> b) & 1));
            q.push_back(12);
          end
        end
      end else begin
        if (start) m_tag = "R8";
        if (baud_tick) begin
          if (q.size() == 0) begin
            m_done = 1; m_busy = 0; m_txd = 1; m_tag = "R7";
          end else if (q[0] == 2) begin
            if (tx_valid) begin
              void'(q.pop_front());
              m_txd = 0; m_tag = "R5";
            end else begin
              m_txd = 1; m_tag = "R9";
            end
          end else begin
            int e;
            e = q.pop_front();
            m_tag = tag_of(e);
            m_txd = (e == 3 || e == 11 || e == 12);
          end
        end
      end
      if (tx_ready && tx_valid) idx++;
    end
  end

  task automatic run_frame(input int len, input int bytes[$],
                           input int stall_at, input int stall_len,
                           input bit poke_busy);
    int d0;
    @(posedge clk);
    frm = bytes; idx = 0; req_len = 2'(len); req_en = 1; req_start = 1;
    d0 = done_seen;
    repeat (3) @(posedge clk);
    chk(busy === 1'b1, "R2", "busy after enabled start", int'(busy), 1);
    for (int c = 0; c < 2000 && m_busy; c++) begin
      @(posedge clk);
      if (poke_busy && (c == 40 || c == 150)) req_start = 1;
      if (stall_len > 0 && c == stall_at) stall = 1;
      if (stall_len > 0 && c == stall_at + stall_len) stall = 0;
    end
    stall = 0;
    repeat (3) @(posedge clk);
    chk(idx == bytes.size(), "R6", "bytes taken", idx, bytes.size());
    chk(done_seen - d0 == 1, "R7", "done pulses", done_seen - d0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({txd, busy, done, tx_ready} === 4'b1000, "R1", "reset state",
        int'({txd, busy, done, tx_ready}), 8);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    // R2: start with master operation disabled
    req_en = 0; frm = '{8'h55, 8'h11}; idx = 0; req_start = 1;
    repeat (12) @(posedge clk);
    chk(busy === 1'b0 && txd === 1'b1, "R2", "disabled start ignored",
        int'({busy, txd}), 1);
    run_frame(0, '{8'h55, 8'h3C, 8'hA1, 8'h0F}, 0, 0, 0);
    run_frame(3, '{8'h55, 8'hC1, 8'hFF, 8'h00, 8'h7E}, 0, 0, 0);
    run_frame(1, '{8'h55, 8'h92}, 0, 0, 1);               // R8
    run_frame(2, '{8'h55, 8'h2A, 8'h81, 8'h44}, 120, 50, 0); // R9
    run_frame(1, '{8'h55, 8'h80}, 0, 0, 0);
    finish_run();
  end

endmodule